// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard (clock and data) after they enter the chip. It rebuilds the 11-bit frames the keyboard sends and keeps each valid scan code in a small first-in first-out store for a consumer to collect. Both lines pass through two-flop synchronisers. The receiver samples the data line each time the synchronised keyboard clock falls.

Each frame is checked in three places. A start bit that reads high is not treated as a frame start. A bad odd-parity bit makes the block raise a one-cycle request to a separate transmitter, which then sends the resend command byte to the keyboard. A stop bit that reads low throws the byte away. A watchdog counts ticks of an external 1 µs strobe. If the keyboard clock stays quiet for the set number of ticks in the middle of a frame, the receiver goes back to idle, so the next frame starts clean.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, `code_valid_o` and `resend_req_o` are low and the store is empty.
- R2: A frame is one low start bit, then eight data bits least significant bit first, then a parity bit, then a high stop bit. The data line is sampled on each falling edge of the synchronised keyboard clock, and an accepted frame delivers its eight data bits unchanged on `code_o`.
- R3: A falling edge whose data sample is high while the receiver is idle does not start a frame and stores nothing.
- R4: Parity is odd. The parity bit must be 1 when the data byte has an even number of ones and 0 otherwise. A frame that matches, with a high stop bit, stores its byte.
- R5: On a parity mismatch the receiver returns to idle, stores nothing and drives `resend_req_o` high for exactly one clock. `resend_byte_o` always carries 0xFE.
- R6: After the stop bit the receiver always returns to idle. A stop bit that samples low discards the byte.
- R7: While a frame is in progress, `TIMEOUT_TICKS` pulses of `tick_i` with no falling edge of the keyboard clock return the receiver to idle. Each received bit restarts this count.
- R8: Stored bytes leave in arrival order. `code_o` shows the oldest byte while `code_valid_o` is high, `pop_i` removes it, and the read and write positions wrap around the store.
- R9: A byte accepted while the store already holds `FIFO_DEPTH` bytes is dropped, and the stored bytes are kept.
- R10: `pop_i` while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe every microsecond |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| pop_i | input | 1 | Removes the oldest stored byte |
| code_o | output | 8 | Oldest stored scan code |
| code_valid_o | output | 1 | Store holds at least one byte |
| resend_req_o | output | 1 | One-cycle request to send the resend command |
| resend_byte_o | output | 8 | Command byte for the transmitter (0xFE) |

## Verification
Clean frames are sent with data bytes of different one-counts (0x1C, 0x00, 0xFF, 0xA5). A byte-order or parity-polarity fault would show up there. Frames with a flipped parity bit must raise one resend pulse and store nothing. Frames with a low stop bit must vanish without a pulse. A single high start pulse followed by a clean frame tells real start detection apart from blind bit counting. A frame cut off after three bits and then left quiet past the timeout, followed by a clean frame, shows that the watchdog resynchronises the receiver. Five frames in a row into a four-entry store, then pops past the wrap point and a pop on an empty store, exercise ordering, dropping and pointer wrap.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2,
    ST_STOP = 2'd3
  } rx_state_e;

  localparam logic [7:0] RESEND_CMD = 8'hFE;
  localparam logic [7:0] SHIFT_SEED = 8'h80;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic clk_fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_sh_q, clk_sh_d;
  logic [STAGES-1:0] dat_sh_q, dat_sh_d;
  logic              clk_last_q;

  always_comb begin
    clk_sh_d = {clk_sh_q[STAGES-2:0], ps2_clk_i};
    dat_sh_d = {dat_sh_q[STAGES-2:0], ps2_dat_i};
  end

  // idle lines are high, so reset to high to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh_q   <= '1;
      dat_sh_q   <= '1;
      clk_last_q <= 1'b1;
    end else begin
      clk_sh_q   <= clk_sh_d;
      dat_sh_q   <= dat_sh_d;
      clk_last_q <= clk_sh_q[STAGES-1];
    end
  end

  assign clk_fall_o = clk_last_q & ~clk_sh_q[STAGES-1];
  assign dat_o      = dat_sh_q[STAGES-1];
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       push_o,
  output logic [7:0] push_data_o,
  output logic       resend_o
);
  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);

  rx_state_e        st_q, st_d;
  logic [7:0]       sh_q, sh_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             push_q, push_d;
  logic [7:0]       pdata_q, pdata_d;
  logic             resend_q, resend_d;
  logic             expire;

  assign expire = tick_i && (tmr_q == TMR_W'(TIMEOUT_TICKS - 1));

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    pdata_d  = pdata_q;
    push_d   = 1'b0;
    resend_d = 1'b0;
    if (st_q == ST_IDLE)  tmr_d = '0;
    else if (tick_i)      tmr_d = tmr_q + 1'b1;
    else                  tmr_d = tmr_q;
    if (fall_i) begin
      tmr_d = '0;
      unique case (st_q)
        ST_IDLE: if (!dat_i) begin
          st_d = ST_DATA;
          sh_d = SHIFT_SEED;
        end
        ST_DATA: begin
          sh_d = {dat_i, sh_q[7:1]};
          if (sh_q[0]) st_d = ST_PAR;
        end
        ST_PAR: begin
          if (dat_i == ~^sh_q) st_d = ST_STOP;
          else begin
            st_d     = ST_IDLE;
            resend_d = 1'b1;
          end
        end
        ST_STOP: begin
          st_d    = ST_IDLE;
          push_d  = dat_i;
          pdata_d = sh_q;
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (st_q != ST_IDLE && expire) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sh_q     <= '0;
      tmr_q    <= '0;
      push_q   <= 1'b0;
      pdata_q  <= '0;
      resend_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sh_q     <= sh_d;
      tmr_q    <= tmr_d;
      push_q   <= push_d;
      pdata_q  <= pdata_d;
      resend_q <= resend_d;
    end
  end

  assign push_o      = push_q;
  assign push_data_o = pdata_q;
  assign resend_o    = resend_q;

  p_start_high_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fall_i && dat_i) |=> (st_q == ST_IDLE && !push_q));
  p_resend_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resend_q |=> !resend_q);
  p_resend_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resend_q |-> (st_q == ST_IDLE && !push_q));
  p_stop_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && fall_i) |=> st_q == ST_IDLE);
  p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !fall_i && expire) |=> st_q == ST_IDLE);
endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, do_wr, do_rd;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = push_i && !full;
  assign do_rd = pop_i && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_wr) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_rd) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem_q[g] <= '0;
      else if (do_wr && wr_q == PTR_W'(g))    mem_q[g] <= push_data_i;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign valid_o = !empty;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (cnt_q == CNT_W'(DEPTH) && $stable(wr_q)));
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !push_i) |=> (cnt_q == '0 && $stable(rd_q)));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 100,
  parameter int FIFO_DEPTH    = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       pop_i,
  output logic [7:0] code_o,
  output logic       code_valid_o,
  output logic       resend_req_o,
  output logic [7:0] resend_byte_o
);
  logic       fall, dat_s, push;
  logic [7:0] push_data;

  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps2_clk_i  (ps2_clk_i),
    .ps2_dat_i  (ps2_dat_i),
    .clk_fall_o (fall),
    .dat_o      (dat_s)
  );

  kbd_frame_fsm #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .fall_i      (fall),
    .dat_i       (dat_s),
    .push_o      (push),
    .push_data_o (push_data),
    .resend_o    (resend_req_o)
  );

  kbd_code_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_i),
    .head_o      (code_o),
    .valid_o     (code_valid_o)
  );

  assign resend_byte_o = RESEND_CMD;

  p_resend_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req_o |-> !push);
endmodule

// File: tb/kbd_frame_rx_tb_top.sv
module kbd_frame_rx_tb_top;
  localparam int DEPTH = 4;
  localparam int TMO   = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic kclk = 1'b1;
  logic kdat = 1'b1;
  logic pop = 1'b0;
  logic [7:0] code;
  logic code_valid, resend_req;
  logic [7:0] resend_byte;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int resend_seen = 0;
  int resend_exp = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  kbd_frame_rx #(.TIMEOUT_TICKS(TMO), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ps2_clk_i(kclk),
    .ps2_dat_i(kdat), .pop_i(pop), .code_o(code), .code_valid_o(code_valid),
    .resend_req_o(resend_req), .resend_byte_o(resend_byte));

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt + 1) % 4;
    tick     <= (tick_cnt == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference comparison on every clock while the line is quiet
  always @(negedge clk) begin
    if (rst_n && resend_req) resend_seen++;
    if (cmp_en && !done) begin
      chk(code_valid == (exp_q.size() != 0), "R8 valid", code_valid, exp_q.size() != 0);
      if (exp_q.size() != 0) chk(code == exp_q[0][7:0], "R2/R8 head", code, exp_q[0]);
      chk(resend_byte == 8'hFE, "R5 byte", resend_byte, 8'hFE);
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk) kdat = b;
    repeat (5) @(negedge clk);
    kclk = 1'b0;
    repeat (10) @(negedge clk);
    kclk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // par_flip: wrong parity; stop_bit: value of the stop bit
  task automatic send_frame(input logic [7:0] b, input bit par_flip, input bit stop_bit);
    cmp_en = 1'b0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ par_flip);
    send_bit(stop_bit);
    kdat = 1'b1;
    repeat (6) @(negedge clk);
    if (par_flip) resend_exp++;
    else if (stop_bit && exp_q.size() < DEPTH) exp_q.push_back(int'(b));
    chk(resend_seen == resend_exp, "R5 resend count", resend_seen, resend_exp);
    cmp_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(posedge clk) #1;
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    @(negedge clk) pop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!code_valid, "R1 valid", code_valid, 0);
    chk(!resend_req, "R1 resend", resend_req, 0);
    cmp_en = 1'b1;
    repeat (4) @(negedge clk);

    send_frame(8'h1C, 0, 1);          // R2 R4 clean frame
    send_frame(8'h00, 0, 1);          // R4 zero ones
    send_frame(8'hFF, 0, 1);          // R4 eight ones
    repeat (3) do_pop();
    chk(!code_valid, "R8 drained", code_valid, 0);

    send_frame(8'h5A, 1, 1);          // R5 bad parity
    send_frame(8'h3C, 0, 0);          // R6 low stop bit
    chk(!code_valid, "R6 discarded", code_valid, 0);

    cmp_en = 1'b0;                    // R3 lone high start pulse
    send_bit(1'b1);
    repeat (6) @(negedge clk);
    cmp_en = 1'b1;
    send_frame(8'hA5, 0, 1);
    chk(exp_q.size() == 1 && code == 8'hA5, "R3 resync", code, 8'hA5);
    do_pop();

    cmp_en = 1'b0;                    // R7 cut-off frame then quiet line
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    repeat (TMO * 4 + 80) @(negedge clk);
    chk(resend_seen == resend_exp, "R7 no resend", resend_seen, resend_exp);
    cmp_en = 1'b1;
    send_frame(8'h69, 0, 1);
    chk(code_valid && code == 8'h69, "R7 clean after timeout", code, 8'h69);
    do_pop();

    do_pop();                         // R10 pop on empty
    chk(!code_valid, "R10 empty pop", code_valid, 0);
    send_frame(8'h11, 0, 1);
    chk(code == 8'h11, "R10 store intact", code, 8'h11);

    send_frame(8'h22, 0, 1);          // R9 fill then overflow
    send_frame(8'h33, 0, 1);
    send_frame(8'h44, 0, 1);
    send_frame(8'h55, 0, 1);
    chk(exp_q.size() == DEPTH, "R9 model full", exp_q.size(), DEPTH);
    do_pop();
    chk(code == 8'h22, "R9 order", code, 8'h22);
    send_frame(8'h66, 0, 1);          // R8 wraps write position
    for (int i = 0; i < DEPTH; i++) do_pop();
    chk(!code_valid, "R8 final empty", code_valid, 0);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule